// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block checks one 512-byte data chunk protected by a 24-bit Hamming code. It takes the code that was kept in the flash spare area and the code that the page-read hardware computed over the same chunk. It XORs the two codes into a syndrome and weighs that syndrome. From the weight it decides whether the chunk is clean, carries one flipped data bit that can be repaired, or is beyond repair. When a repair is possible, the block reports the byte offset and bit index of the bad bit. It then repairs the bit in place through a byte-wide memory port by reading the byte, flipping the bit and writing the byte back.

Both codes arrive in the stored byte form. Each code holds twelve even/odd parity pairs: P1, P2, P4 up to P2048, one pair per address bit of the 4096 bit positions. Every byte of a code is kept bit-inverted. The block captures both codes on `start` and counts the set bits of the syndrome a few bits per cycle. It decides in a fixed cycle, then either finishes at once or runs the two-cycle repair. A single-cycle `done` marks the end of the operation. A stored code of all ones marks an erased page, and the block reports it as clean.

The controller has six states:
- IDLE waits for `start` and captures the syndrome (transition IDLE→COUNT).
- COUNT accumulates the syndrome weight, one slice per cycle (COUNT→COUNT until the last slice, then COUNT→JUDGE).
- JUDGE latches status and location (JUDGE→FETCH when the error can be repaired, JUDGE→FINISH otherwise).
- FETCH reads the addressed byte (FETCH→PATCH).
- PATCH writes the byte back with one bit flipped (PATCH→FINISH).
- FINISH pulses `done` (FINISH→IDLE).

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: Code bit layout. Stored bits 0–7 hold the pairs P8, P16, P32 and P64; bits 8–15 hold P128, P256, P512 and P1024; in both ranges each pair is an even bit followed by an odd bit, lowest parity first. Bits 16–17 hold P2048 even, then odd. Bits 18–23 hold P1, P2 and P4 as even/odd pairs. Every stored bit is the inverse of the parity value.
- R2: When the two codes are equal (syndrome zero), `status` becomes 2'b00 and the memory port is not used.
- R3: When `stored_code` is 24'hFFFFFF (erased page), `status` becomes 2'b00 whatever `calc_code` is, and no byte is written.
- R4: When exactly 12 syndrome bits are set, `status` becomes 2'b01. `err_bit` is {P4o, P2o, P1o} of the syndrome, with P4o as the MSB.
- R5: For a repairable error, `err_byte` is the odd-parity syndrome bits P2048o down to P8o, MSB first (range 0–511).
- R6: A repair reads byte `err_byte` (`mem_rd_en`; the data returns one cycle later). In the next cycle it writes the same address with exactly bit `err_bit` inverted. There is exactly one write per repair.
- R7: When exactly one syndrome bit is set (the error lies in a code byte), `status` becomes 2'b10 and no byte is read or written.
- R8: Every other non-zero syndrome weight gives `status` 2'b10 and no memory access.
- R9: `done` is high for one cycle. It comes 6 cycles after the `start` edge when there is no repair and 8 cycles after it when there is one (default slice width of 6).
- R10: `status`, `err_byte` and `err_bit` hold their values until the next accepted `start`. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check; sampled only while idle |
| stored_code | input | 24 | Code read from the spare area (inverted byte form) |
| calc_code | input | 24 | Code computed over the chunk (inverted byte form) |
| status | output | 2 | 00 clean, 01 repaired, 10 uncorrectable |
| err_byte | output | 9 | Byte offset of the repaired bit |
| err_bit | output | 3 | Bit index within the byte |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 9 | Chunk byte address for the repair |
| mem_rd_en | output | 1 | Read request; data is expected on `mem_rdata` next cycle |
| mem_rdata | input | 8 | Byte returned by the chunk memory |
| mem_wr_en | output | 1 | Write strobe for the repaired byte |
| mem_wdata | output | 8 | Repaired byte |

## Verification
Some properties are checked on every cycle: `done` is a single cycle; a write always follows a read of the same address and flips exactly one bit; the memory port is used only with a repaired status; and the outputs stay put while the block is idle and no start arrives. Other behaviour can only be shown by the bench scenarios. These include the location decode from the bit packing, which is swept over all 4096 bit positions. They also include the erased-page rule, the one-bit and other-weight syndromes, the fixed latencies, and a start issued while busy being discarded.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    localparam int PAIRS  = 12;
    localparam int CODE_W = 2 * PAIRS;
    localparam int BYTE_W = PAIRS - 3;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } ecc_status_e;

    typedef struct packed {
        logic [PAIRS-1:0] odd;
        logic [PAIRS-1:0] even;
    } parity_pairs_t;

    // Stored byte form -> parity pairs (index j = log2 of the parity order).
    function automatic parity_pairs_t unpack_code(input logic [CODE_W-1:0] stored);
        parity_pairs_t        p;
        logic [CODE_W-1:0]    r;
        r = ~stored;
        p.even[PAIRS-1] = r[16];
        p.odd[PAIRS-1]  = r[17];
        for (int j = 0; j < 3; j++) begin
            p.even[j] = r[18 + 2*j];
            p.odd[j]  = r[19 + 2*j];
        end
        for (int j = 3; j < PAIRS-1; j++) begin
            p.even[j] = r[2*(j-3)];
            p.odd[j]  = r[2*(j-3) + 1];
        end
        return p;
    endfunction

endpackage

// File: rtl/ecc_syndrome_form.sv
module ecc_syndrome_form
    import ecc_fix_pkg::*;
(
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    output parity_pairs_t     syndrome,
    output logic              erased
);
    parity_pairs_t stored_p;
    parity_pairs_t calc_p;

    always_comb begin
        stored_p = unpack_code(stored_code);
        calc_p   = unpack_code(calc_code);
        syndrome = stored_p ^ calc_p;
        erased   = &stored_code;
    end
endmodule

// File: rtl/ecc_weight_counter.sv
module ecc_weight_counter #(
    parameter int VEC_W   = 24,
    parameter int SLICE_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    input  logic [VEC_W-1:0]           vec,
    output logic [$clog2(VEC_W+1)-1:0] weight,
    output logic                       last
);
    localparam int NSLICE = VEC_W / SLICE_W;
    localparam int CNT_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;
    localparam int WT_W   = $clog2(VEC_W+1);

    logic [CNT_W-1:0]   slice_idx;
    logic [SLICE_W-1:0] slice;
    logic [WT_W-1:0]    slice_ones;

    always_comb begin
        slice      = vec[int'(slice_idx)*SLICE_W +: SLICE_W];
        slice_ones = WT_W'($countones(slice));
        last       = (slice_idx == CNT_W'(NSLICE-1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slice_idx <= '0;
            weight    <= '0;
        end else if (clr) begin
            slice_idx <= '0;
            weight    <= '0;
        end else if (en) begin
            slice_idx <= last ? '0 : slice_idx + 1'b1;
            weight    <= weight + slice_ones;
        end
    end
endmodule

// File: rtl/ecc_locator.sv
module ecc_locator
    import ecc_fix_pkg::*;
(
    input  parity_pairs_t     syndrome,
    output logic [BYTE_W-1:0] byte_off,
    output logic [2:0]        bit_idx
);
    always_comb begin
        bit_idx  = syndrome.odd[2:0];
        byte_off = syndrome.odd[PAIRS-1:3];
    end
endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
    import ecc_fix_pkg::*;
#(
    parameter int SLICE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CODE_W-1:0]  stored_code,
    input  logic [CODE_W-1:0]  calc_code,
    output logic [1:0]         status,
    output logic [BYTE_W-1:0]  err_byte,
    output logic [2:0]         err_bit,
    output logic               busy,
    output logic               done,
    output logic [BYTE_W-1:0]  mem_addr,
    output logic               mem_rd_en,
    input  logic [7:0]         mem_rdata,
    output logic               mem_wr_en,
    output logic [7:0]         mem_wdata
);
    localparam int WT_W       = $clog2(CODE_W+1);
    localparam int FIX_WEIGHT = PAIRS;

    typedef enum logic [2:0] {
        S_IDLE, S_COUNT, S_JUDGE, S_FETCH, S_PATCH, S_FINISH
    } fsm_e;

    fsm_e          state_q, state_d;
    parity_pairs_t syn_now, syn_q;
    logic          erased_now, erased_q;
    logic [WT_W-1:0] weight;
    logic          last_slice;
    logic [BYTE_W-1:0] loc_byte;
    logic [2:0]    loc_bit;
    ecc_status_e   verdict, status_q;
    logic [BYTE_W-1:0] byte_q;
    logic [2:0]    bit_q;
    logic          accept;

    ecc_syndrome_form u_form (
        .stored_code (stored_code),
        .calc_code   (calc_code),
        .syndrome    (syn_now),
        .erased      (erased_now)
    );

    ecc_weight_counter #(.VEC_W(CODE_W), .SLICE_W(SLICE_W)) u_weight (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .en     (state_q == S_COUNT),
        .vec    (syn_q),
        .weight (weight),
        .last   (last_slice)
    );

    ecc_locator u_loc (
        .syndrome (syn_q),
        .byte_off (loc_byte),
        .bit_idx  (loc_bit)
    );

    assign accept = (state_q == S_IDLE) && start;

    always_comb begin
        if (erased_q || (syn_q == '0))
            verdict = ST_CLEAN;
        else if (weight == WT_W'(FIX_WEIGHT))
            verdict = ST_FIXED;
        else
            verdict = ST_FATAL;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)      state_d = S_COUNT;
            S_COUNT:  if (last_slice) state_d = S_JUDGE;
            S_JUDGE:  state_d = (verdict == ST_FIXED) ? S_FETCH : S_FINISH;
            S_FETCH:  state_d = S_PATCH;
            S_PATCH:  state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Captured syndrome and reported result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_q    <= '0;
            erased_q <= 1'b0;
            status_q <= ST_CLEAN;
            byte_q   <= '0;
            bit_q    <= '0;
        end else begin
            if (accept) begin
                syn_q    <= syn_now;
                erased_q <= erased_now;
            end
            if (state_q == S_JUDGE) begin
                status_q <= verdict;
                byte_q   <= (verdict == ST_FIXED) ? loc_byte : '0;
                bit_q    <= (verdict == ST_FIXED) ? loc_bit  : '0;
            end
        end
    end

    // Outputs
    always_comb begin
        status    = status_q;
        err_byte  = byte_q;
        err_bit   = bit_q;
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        mem_addr  = byte_q;
        mem_rd_en = (state_q == S_FETCH);
        mem_wr_en = (state_q == S_PATCH);
        mem_wdata = mem_rdata ^ (8'h01 << bit_q);
    end
endmodule

// File: rtl/ecc_syndrome_fixer_chk.sv
module ecc_syndrome_fixer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] status,
    input logic [8:0] err_byte,
    input logic [2:0] err_bit,
    input logic       busy,
    input logic       done,
    input logic [8:0] mem_addr,
    input logic       mem_rd_en,
    input logic [7:0] mem_rdata,
    input logic       mem_wr_en,
    input logic [7:0] mem_wdata
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));

    assert_one_bit_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_wdata ^ mem_rdata) == 1));

    assert_no_access_unless_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> (status == 2'b01));

    assert_status_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'b11));

    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

    assert_done_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind ecc_syndrome_fixer ecc_syndrome_fixer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .status    (status),
    .err_byte  (err_byte),
    .err_bit   (err_bit),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_rdata (mem_rdata),
    .mem_wr_en (mem_wr_en),
    .mem_wdata (mem_wdata)
);

// File: tb/ecc_syndrome_fixer_test.sv
module ecc_syndrome_fixer_test;
    localparam int LAT_PLAIN = 6;
    localparam int LAT_FIX   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic [1:0]  status;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;
    logic        busy, done;
    logic [8:0]  mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int fails  = 0;
    int wr_count = 0;
    int rd_count = 0;
    int cyc;
    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];

    always #2 clk = ~clk;

    ecc_syndrome_fixer uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_code(stored_code), .calc_code(calc_code),
        .status(status), .err_byte(err_byte), .err_bit(err_bit),
        .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    // Chunk memory model: one-cycle read latency
    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    end

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_count  <= rd_count + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            wr_count      <= wr_count + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Place parity pairs into the stored byte form (syndrome domain).
    function automatic logic [23:0] place(input logic [11:0] ev, input logic [11:0] od);
        logic [23:0] w = '0;
        for (int j = 0; j < 12; j++) begin
            int base;
            if (j < 3)       base = 18 + 2 * j;
            else if (j == 11) base = 16;
            else             base = ((j - 3) / 4) * 8 + 2 * ((j - 3) % 4);
            w[base]     = ev[j];
            w[base + 1] = od[j];
        end
        return w;
    endfunction

    task automatic run_op(input logic [23:0] st, input logic [23:0] ca);
        @(negedge clk);
        stored_code = st;
        calc_code   = ca;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_syn(input logic [23:0] syn, input logic [23:0] seed);
        logic [23:0] x = seed;
        if ((x ^ syn) == 24'hFFFFFF) x = x ^ 24'h000100;
        run_op(x ^ syn, x);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(status == 2'b00 && !done && !busy, "R2 reset status", status, 0);
        check(!mem_rd_en && !mem_wr_en, "R6 reset port idle", {mem_rd_en, mem_wr_en}, 0);

        // R1 R4 R5 R6 R9: sweep every bit position of the chunk
        for (int pos = 0; pos < 4096; pos++) begin
            logic [11:0] p12 = 12'(pos);
            logic [7:0]  mask = 8'h01 << p12[2:0];
            int          b = int'(p12[11:3]);
            w0 = wr_count;
            run_syn(place(~p12, p12), 24'(pos * 40503 + 24'h5A5A5A));
            check(status == 2'b01, "R4 R1 status", status, 1);
            check(err_bit == p12[2:0], "R4 bit index", err_bit, p12[2:0]);
            check(err_byte == p12[11:3], "R5 byte offset", err_byte, p12[11:3]);
            check(mem[b] == (exp_mem[b] ^ mask), "R6 byte repaired", mem[b], exp_mem[b] ^ mask);
            check(wr_count - w0 == 1, "R6 one write", wr_count - w0, 1);
            check(cyc == LAT_FIX, "R9 repair latency", cyc, LAT_FIX);
            exp_mem[b] = exp_mem[b] ^ mask;
        end

        // R7: one-bit syndromes (error in code bytes)
        for (int i = 0; i < 24; i++) begin
            w0 = rd_count;
            run_syn(24'h1 << i, 24'(i * 977 + 24'h123456));
            check(status == 2'b10, "R7 code-byte error", status, 2);
            check(rd_count == w0, "R7 no data access", rd_count - w0, 0);
            check(cyc == LAT_PLAIN, "R9 plain latency", cyc, LAT_PLAIN);
        end

        // R2: zero syndrome
        for (int i = 0; i < 8; i++) begin
            w0 = rd_count;
            run_syn(24'h0, 24'(i * 2097143 + 7));
            check(status == 2'b00, "R2 clean", status, 0);
            check(rd_count == w0, "R2 no data access", rd_count - w0, 0);
            check(err_byte == 9'd0 && err_bit == 3'd0, "R2 location zero", {err_byte, err_bit}, 0);
        end

        // R3: erased page, including a computed code that would look repairable
        for (int i = 0; i < 6; i++) begin
            logic [23:0] ca = (i == 0) ? ~place(12'h0A5 ^ 12'hFFF, 12'h0A5) : 24'(i * 3331);
            w0 = rd_count;
            run_op(24'hFFFFFF, ca);
            check(status == 2'b00, "R3 erased page", status, 0);
            check(rd_count == w0, "R3 no data access", rd_count - w0, 0);
        end

        // R8: other weights
        begin
            int wl [6] = '{2, 3, 11, 13, 23, 24};
            for (int k = 0; k < 6; k++) begin
                logic [23:0] s = (wl[k] == 24) ? 24'hFFFFFF : ((24'h1 << wl[k]) - 24'h1);
                w0 = rd_count;
                run_syn(s, 24'h00F00F);
                check(status == 2'b10, "R8 other weight", status, 2);
                check(rd_count == w0, "R8 no data access", rd_count - w0, 0);
            end
        end

        // R4 R5: weight 12 without complementary pairs (bits 0..11 set:
        // pairs P8..P256 fully set) -> byte 63, bit 0, repaired
        w0 = wr_count;
        run_syn(24'h000FFF, 24'h3C3C3C);
        check(status == 2'b01, "R4 weight twelve", status, 1);
        check(err_byte == 9'd63 && err_bit == 3'd0, "R5 odd-bit location", {err_byte, err_bit}, {9'd63, 3'd0});
        check(wr_count - w0 == 1, "R6 one write", wr_count - w0, 1);
        exp_mem[63] = exp_mem[63] ^ 8'h01;
        check(mem[63] == exp_mem[63], "R6 byte repaired", mem[63], exp_mem[63]);

        // R10: start while busy is ignored
        begin
            logic [11:0] p12 = 12'd1234;
            logic [23:0] s = place(~p12, p12);
            @(negedge clk);
            stored_code = s ^ 24'h010203;
            calc_code   = 24'h010203;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            stored_code = 24'h000000;
            calc_code   = 24'h000001;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc = 0;
            while (!done && cyc < 40) begin
                @(negedge clk);
                cyc++;
            end
            check(status == 2'b01, "R10 busy start ignored", status, 1);
            check(err_byte == p12[11:3] && err_bit == p12[2:0], "R10 first op location",
                  {err_byte, err_bit}, p12);
            exp_mem[int'(p12[11:3])] = exp_mem[int'(p12[11:3])] ^ (8'h01 << p12[2:0]);
            repeat (6) @(negedge clk);
            check(status == 2'b01 && err_byte == p12[11:3] && err_bit == p12[2:0],
                  "R10 result held", {status, err_byte, err_bit}, {2'b01, p12});
            check(!busy, "R10 no restart", busy, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule